// File: doc/BRIEF.md
# Dual-Port Token Flag Bank

This block holds a bank of independent token flags that two requesters, a left port and a right port, share as hardware locks for software. A port reaches the flags when its memory enable (active low) is deasserted, that is high, and its flag select (active low) is asserted, that is low. The low address bits pick one flag. A write looks only at data bit 0. Writing 0 asks for the token and writing 1 gives it back. A read returns that port's own view of the flag, copied onto every data bit.

Each flag is a small state machine with five named states. In `FLAG_IDLE` nobody holds the token. In `FLAG_LEFT` or `FLAG_RIGHT` one side holds it. In `FLAG_LEFT_RWAIT` or `FLAG_RIGHT_LWAIT` one side holds it and the other side has a request waiting.

The transitions are named as follows. **take** moves from idle to a holding state when a port writes 0. **tie** covers both ports writing 0 to an idle flag in the same cycle: the left port gets the token and the right request waits. **queue** records a 0 written by the side that does not hold the token. **withdraw** clears a waiting request when its own side writes 1. **handoff** passes the token straight to the waiting side when the holder writes 1. **drop** returns the flag to idle when the holder writes 1 and nothing is waiting. Any other write leaves the state where it is.

Top module: `sem_bank`

## Requirements
- R1: A port reaches the flags only when its `*_mem_en_n` is 1 and its `*_flag_sel_n` is 0. In any other case its writes change no flag and its `*_rdata` is 8'h00.
- R2: The address selects one of 8 flags. A write (`*_we_n`=0) uses only `*_wdata[0]`: 0 is a request and 1 is a release. Bits 7:1 are ignored.
- R3: A read (`*_we_n`=1) returns the port's view copied onto all 8 bits. The value is 8'h00 when that port holds the token and 8'hFF otherwise. The read takes effect in the same cycle, without a clock edge.
- R4: While a flag is idle, both ports read 8'hFF from it.
- R5: A request to an idle flag grants it at the next clock edge. The holder then reads 8'h00 and the other port reads 8'hFF.
- R6: A request from the side that does not hold the token leaves both reads unchanged, but the request is remembered.
- R7: When the holder writes 1, a waiting request from the other side takes the token at the same edge. If nothing is waiting, the flag becomes idle.
- R8: A write of 1 from a port that holds neither the token nor a request leaves the flag unchanged.
- R9: If both ports request an idle flag in the same cycle, the left port gets the token and the right request waits.
- R10: A port that writes 1 while its request is waiting cancels that request.
- R11: After reset every flag is idle.
- R12: The two ports never hold the same flag at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_mem_en_n | input | 1 | Left memory enable, active low; must be 1 for flag access |
| l_flag_sel_n | input | 1 | Left flag select, active low |
| l_we_n | input | 1 | Left write strobe, active low |
| l_addr | input | 3 | Left flag index |
| l_wdata | input | 8 | Left write data (bit 0 used) |
| l_rdata | output | 8 | Left read data |
| r_mem_en_n | input | 1 | Right memory enable, active low; must be 1 for flag access |
| r_flag_sel_n | input | 1 | Right flag select, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_addr | input | 3 | Right flag index |
| r_wdata | input | 8 | Right write data (bit 0 used) |
| r_rdata | output | 8 | Right read data |

## Verification
The hardest states to reach from the ports are the two waiting states. A waiting request is invisible to reads, so it shows only when it later turns into a handoff or fails to, after a withdraw. Directed sequences build each waiting state on its own flag. They then release or withdraw, and cover the tie of two requests in the same cycle. Random traffic is spread over all eight flags, mostly with access enabled and with reads mixed into the writes. This lets a queue, a withdraw and a handoff land on the same flag across many cycles, and a bench model of owner and waiting bits predicts every read.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic [2:0] {
        FLAG_IDLE        = 3'd0,
        FLAG_LEFT        = 3'd1,
        FLAG_RIGHT       = 3'd2,
        FLAG_LEFT_RWAIT  = 3'd3,
        FLAG_RIGHT_LWAIT = 3'd4
    } flag_state_e;

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
    parameter int NUM_FLAGS = 8,
    parameter int DATA_W    = 8,
    localparam int ADDR_W   = $clog2(NUM_FLAGS)
) (
    input  logic                 mem_en_n,
    input  logic                 flag_sel_n,
    input  logic                 we_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [NUM_FLAGS-1:0] req_vec,
    output logic [NUM_FLAGS-1:0] rel_vec,
    output logic                 rd_act
);
    logic access;
    logic wr_act;

    assign access = mem_en_n & ~flag_sel_n;
    assign wr_act = access & ~we_n;
    assign rd_act = access & we_n;

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_hit
        logic hit;
        assign hit        = wr_act && (addr == ADDR_W'(i));
        assign req_vec[i] = hit & ~wdata[0];
        assign rel_vec[i] = hit &  wdata[0];
    end
endmodule

// File: rtl/sem_flag_fsm.sv
module sem_flag_fsm
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_req,
    input  logic l_rel,
    input  logic r_req,
    input  logic r_rel,
    output logic l_own,
    output logic r_own,
    output logic l_pend,
    output logic r_pend
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: begin
                if (l_req && r_req) state_d = FLAG_LEFT_RWAIT;   // tie
                else if (l_req)     state_d = FLAG_LEFT;         // take
                else if (r_req)     state_d = FLAG_RIGHT;        // take
            end
            FLAG_LEFT: begin
                if (l_rel && r_req) state_d = FLAG_RIGHT;        // handoff
                else if (l_rel)     state_d = FLAG_IDLE;         // drop
                else if (r_req)     state_d = FLAG_LEFT_RWAIT;   // queue
            end
            FLAG_RIGHT: begin
                if (r_rel && l_req) state_d = FLAG_LEFT;         // handoff
                else if (r_rel)     state_d = FLAG_IDLE;         // drop
                else if (l_req)     state_d = FLAG_RIGHT_LWAIT;  // queue
            end
            FLAG_LEFT_RWAIT: begin
                if (l_rel && r_rel) state_d = FLAG_IDLE;         // drop
                else if (l_rel)     state_d = FLAG_RIGHT;        // handoff
                else if (r_rel)     state_d = FLAG_LEFT;         // withdraw
            end
            FLAG_RIGHT_LWAIT: begin
                if (r_rel && l_rel) state_d = FLAG_IDLE;         // drop
                else if (r_rel)     state_d = FLAG_LEFT;         // handoff
                else if (l_rel)     state_d = FLAG_RIGHT;        // withdraw
            end
            default: state_d = FLAG_IDLE;
        endcase
    end

    always_comb begin
        l_own  = (state_q == FLAG_LEFT)  || (state_q == FLAG_LEFT_RWAIT);
        r_own  = (state_q == FLAG_RIGHT) || (state_q == FLAG_RIGHT_LWAIT);
        l_pend = (state_q == FLAG_RIGHT_LWAIT);
        r_pend = (state_q == FLAG_LEFT_RWAIT);
    end
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
    parameter int NUM_FLAGS = 8,
    parameter int DATA_W    = 8,
    localparam int ADDR_W   = $clog2(NUM_FLAGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_mem_en_n,
    input  logic              l_flag_sel_n,
    input  logic              l_we_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_mem_en_n,
    input  logic              r_flag_sel_n,
    input  logic              r_we_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    logic [NUM_FLAGS-1:0] l_req, l_rel, r_req, r_rel;
    logic [NUM_FLAGS-1:0] l_own, r_own, l_pend, r_pend;
    logic                 l_rd, r_rd;

    sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_dec_l (
        .mem_en_n(l_mem_en_n), .flag_sel_n(l_flag_sel_n), .we_n(l_we_n),
        .addr(l_addr), .wdata(l_wdata),
        .req_vec(l_req), .rel_vec(l_rel), .rd_act(l_rd)
    );

    sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_dec_r (
        .mem_en_n(r_mem_en_n), .flag_sel_n(r_flag_sel_n), .we_n(r_we_n),
        .addr(r_addr), .wdata(r_wdata),
        .req_vec(r_req), .rel_vec(r_rel), .rd_act(r_rd)
    );

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        sem_flag_fsm u_fsm (
            .clk(clk), .rst_n(rst_n),
            .l_req(l_req[i]), .l_rel(l_rel[i]),
            .r_req(r_req[i]), .r_rel(r_rel[i]),
            .l_own(l_own[i]), .r_own(r_own[i]),
            .l_pend(l_pend[i]), .r_pend(r_pend[i])
        );
    end

    always_comb begin
        l_rdata = '0;
        r_rdata = '0;
        if (l_rd) l_rdata = {DATA_W{~l_own[l_addr]}};
        if (r_rd) r_rdata = {DATA_W{~r_own[r_addr]}};
    end
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
    parameter int NUM_FLAGS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 l_mem_en_n,
    input logic                 l_flag_sel_n,
    input logic                 r_mem_en_n,
    input logic                 r_flag_sel_n,
    input logic [NUM_FLAGS-1:0] l_req,
    input logic [NUM_FLAGS-1:0] r_req,
    input logic [NUM_FLAGS-1:0] l_rel,
    input logic [NUM_FLAGS-1:0] r_rel,
    input logic [NUM_FLAGS-1:0] l_own,
    input logic [NUM_FLAGS-1:0] r_own,
    input logic [NUM_FLAGS-1:0] r_pend
);
    logic no_access;
    assign no_access = !(l_mem_en_n && !l_flag_sel_n) && !(r_mem_en_n && !r_flag_sel_n);

    AST_EXCL_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (l_own & r_own) == '0); // R12

    AST_IDLE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        |(l_req & ~l_own & ~r_own) |=> |(l_own & $past(l_req & ~l_own & ~r_own))); // R5

    AST_HANDOFF_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        |(l_rel & l_own & r_pend & ~r_rel) |=> |(r_own & $past(l_rel & l_own & r_pend & ~r_rel))); // R7

    AST_TIE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        |(l_req & r_req & ~l_own & ~r_own) |=> |(l_own & $past(l_req & r_req & ~l_own & ~r_own))); // R9

    AST_NO_ACCESS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        no_access |=> ($stable(l_own) && $stable(r_own))); // R1
endmodule

bind sem_bank sem_bank_chk #(.NUM_FLAGS(NUM_FLAGS)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_mem_en_n(l_mem_en_n), .l_flag_sel_n(l_flag_sel_n),
    .r_mem_en_n(r_mem_en_n), .r_flag_sel_n(r_flag_sel_n),
    .l_req(l_req), .r_req(r_req), .l_rel(l_rel), .r_rel(r_rel),
    .l_own(l_own), .r_own(r_own), .r_pend(r_pend)
);

// File: tb/tb_sem_bank.sv
module tb_sem_bank;
    localparam int NF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       l_mem_en_n = 1'b1, l_flag_sel_n = 1'b1, l_we_n = 1'b1;
    logic [2:0] l_addr = '0;
    logic [7:0] l_wdata = '0;
    logic [7:0] l_rdata;
    logic       r_mem_en_n = 1'b1, r_flag_sel_n = 1'b1, r_we_n = 1'b1;
    logic [2:0] r_addr = '0;
    logic [7:0] r_wdata = '0;
    logic [7:0] r_rdata;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // model: owner 0 idle, 1 left, 2 right
    int owner [NF];
    bit lpend [NF];
    bit rpend [NF];

    always #4 clk = ~clk;

    sem_bank dut (.*);

    function automatic logic [7:0] exp_read(int own, bit is_left);
        if ((is_left && own == 1) || (!is_left && own == 2)) return 8'h00;
        return 8'hFF;
    endfunction

    task automatic check(logic [7:0] act, logic [7:0] exp, string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic model_step(bit lq, bit ll, int la, bit rq, bit rl, int ra);
        for (int i = 0; i < NF; i++) begin
            bit q_l = lq && la == i, x_l = ll && la == i;
            bit q_r = rq && ra == i, x_r = rl && ra == i;
            if (owner[i] == 0) begin
                if (q_l) begin owner[i] = 1; rpend[i] = q_r; end
                else if (q_r) owner[i] = 2;
            end else if (owner[i] == 1) begin
                if (x_l) begin
                    owner[i] = (!x_r && (rpend[i] || q_r)) ? 2 : 0;
                    rpend[i] = 0;
                end else begin
                    if (x_r) rpend[i] = 0;
                    if (q_r) rpend[i] = 1;
                end
            end else begin
                if (x_r) begin
                    owner[i] = (!x_l && (lpend[i] || q_l)) ? 1 : 0;
                    lpend[i] = 0;
                end else begin
                    if (x_l) lpend[i] = 0;
                    if (q_l) lpend[i] = 1;
                end
            end
        end
    endtask

    // op: 0 idle, 1 read, 2 write; en/sel are the raw pin values
    task automatic cyc(int lop, int la, logic [7:0] lw, bit len, bit lsel,
                       int rop, int ra, logic [7:0] rw, bit ren, bit rsel, string tag);
        bit lacc, racc;
        @(negedge clk);
        l_mem_en_n = len; l_flag_sel_n = lsel; l_we_n = (lop != 2);
        l_addr = 3'(la); l_wdata = lw;
        r_mem_en_n = ren; r_flag_sel_n = rsel; r_we_n = (rop != 2);
        r_addr = 3'(ra); r_wdata = rw;
        if (lop == 0) begin l_flag_sel_n = 1'b1; end
        if (rop == 0) begin r_flag_sel_n = 1'b1; end
        lacc = l_mem_en_n && !l_flag_sel_n;
        racc = r_mem_en_n && !r_flag_sel_n;
        #1;
        if (lop == 1) check(l_rdata, lacc ? exp_read(owner[la], 1) : 8'h00,
                            lacc ? {tag, " R3 left"} : {tag, " R1 left"});
        if (rop == 1) check(r_rdata, racc ? exp_read(owner[ra], 0) : 8'h00,
                            racc ? {tag, " R3 right"} : {tag, " R1 right"});
        @(posedge clk);
        model_step(lacc && lop == 2 && !lw[0], lacc && lop == 2 && lw[0], la,
                   racc && rop == 2 && !rw[0], racc && rop == 2 && rw[0], ra);
    endtask

    task automatic lw(int a, logic [7:0] d);
        cyc(2, a, d, 1, 0, 0, 0, 8'h0, 1, 1, "wr");
    endtask
    task automatic rw(int a, logic [7:0] d);
        cyc(0, 0, 8'h0, 1, 1, 2, a, d, 1, 0, "wr");
    endtask
    task automatic rd_both(int a, string tag);
        cyc(1, a, 8'h0, 1, 0, 1, a, 8'h0, 1, 0, tag);
    endtask

    initial begin
        for (int i = 0; i < NF; i++) begin owner[i] = 0; lpend[i] = 0; rpend[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NF; i++) rd_both(i, "R11 R4 reset idle");

        lw(3, 8'h00);            rd_both(3, "R5 take");
        rw(3, 8'h00);            rd_both(3, "R6 queue");
        lw(3, 8'h01);            rd_both(3, "R7 handoff");
        rw(3, 8'h01);            rd_both(3, "R7 drop");

        lw(5, 8'h01);            rd_both(5, "R8 stray release");
        lw(5, 8'hFE);            rd_both(5, "R2 bit0 only");
        rw(5, 8'hFF);            rd_both(5, "R8 stray release holder side");
        lw(5, 8'h01);            rd_both(5, "R2 release");

        cyc(2, 6, 8'h00, 1, 0, 2, 6, 8'h00, 1, 0, "tie");
        rd_both(6, "R9 tie left wins");
        lw(6, 8'h01);            rd_both(6, "R9 right waited");
        rw(6, 8'h01);            rd_both(6, "R9 cleanup");

        lw(2, 8'h00); rw(2, 8'h00); rw(2, 8'h01);
        lw(2, 8'h01);            rd_both(2, "R10 withdraw");

        cyc(2, 1, 8'h00, 0, 0, 2, 1, 8'h00, 1, 1, "R1 blocked");
        rd_both(1, "R1 no grant");
        cyc(1, 1, 8'h00, 0, 0, 1, 1, 8'h00, 0, 1, "R1 idle read");

        for (int i = 0; i < NF; i++) rd_both(i, "R2 other flags");

        void'($urandom(32'd4711));
        for (int n = 0; n < 4000; n++) begin
            int lop = int'($urandom_range(0, 2));
            int rop = int'($urandom_range(0, 2));
            cyc(lop, int'($urandom_range(0, NF - 1)), 8'($urandom),
                ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) == 0),
                rop, int'($urandom_range(0, NF - 1)), 8'($urandom),
                ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) == 0),
                "random R6 R7 R10");
        end
        for (int i = 0; i < NF; i++) rd_both(i, "R12 final");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule